// File: doc/BRIEF.md
# Plug-and-Play Initiation Key Detector

This block sits beside the address port of a plug-and-play expansion card. While the card controller reports that the card is still waiting for its key, the block compares each byte the host writes to the address port against a byte sequence that the card generates itself. An 8-bit linear feedback shift register produces that sequence. When a run of 32 consecutive writes matches, the block raises a single-cycle acceptance pulse. The card controller uses this pulse to move the card into its sleep state.

A write that does not match the expected byte discards all progress. The comparison then restarts from the seed. Writes made while the card is not waiting for its key leave the comparison untouched. Every write, whatever the card state, is also captured in an 8-bit address latch. That latch holds the register index that the card's data-port logic decodes.

Top module: `pnp_key_detect`

## Requirements
- R1: After reset, `key_ok` is 0 and `addr_latch` is 0x00, the generator holds the seed 0x6A, and the match count is zero.
- R2: Each step of the generator shifts its value right by one bit and sets the new bit 7 to the XOR of the old bits 0 and 1. Starting from the seed, the expected bytes therefore begin 0x6A, 0xB5, 0xDA, 0xED.
- R3: A write (`wr_en`=1) made while `wait_key`=1 whose byte equals the current expected byte advances the generator one step and adds one to the match count.
- R4: A write made while `wait_key`=1 whose byte differs from the expected byte reloads the seed and clears the count. This holds even when that byte equals 0x6A, so such a byte never counts as the first byte of a new run.
- R5: The 32nd consecutive matching write drives `key_ok` to 1 for exactly one cycle, in the cycle that follows the clock edge that captured that write. No other event drives `key_ok` high.
- R6: The write that completes the key also reloads the seed and clears the count, so a following attempt must send the whole 32-byte sequence again.
- R7: A write made while `wait_key`=0 leaves the generator and the count unchanged and never causes a pulse.
- R8: Cycles with `wr_en`=0 leave the generator and the count unchanged, so a key may be sent with idle gaps between its bytes.
- R9: Every write loads `wr_byte` into `addr_latch`, whatever the value of `wait_key`, and the new value is visible from the following cycle. Without a write the latch holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Address-port write strobe, one cycle per write |
| wr_byte | input | 8 | Byte written to the address port |
| wait_key | input | 1 | High while the card controller is in its waiting-for-key state |
| key_ok | output | 1 | One-cycle pulse when the full key has been received |
| addr_latch | output | 8 | Last byte written to the address port |

## Verification
Two of the block's functions can fall on the same write: loading the address latch and comparing the byte against the key. The second pair is completing the key and the card controller leaving the waiting state. The bench sends the 32nd byte in the very cycle that `wait_key` drops. That write must still load the latch, but it must neither count nor pulse. The same byte, resent once `wait_key` returns, must complete the key. The reference model updates the latch and the key progress independently on each write, and it is compared with both outputs on every clock.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

    localparam int unsigned KEY_W_DEF   = 8;
    localparam int unsigned KEY_LEN_DEF = 32;
    localparam logic [7:0]  KEY_SEED_DEF = 8'h6A;

endpackage

// File: rtl/pnp_key_lfsr_step.sv
// One step of the key sequence generator: a right shift whose new top bit
// is the XOR of the two lowest bits of the current value and an injected bit.
module pnp_key_lfsr_step #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         inject,
    output logic [W-1:0] nxt
);
    generate
        for (genvar i = 0; i < W - 1; i++) begin : g_shift
            assign nxt[i] = cur[i+1];
        end
    endgenerate

    assign nxt[W-1] = cur[0] ^ cur[1] ^ inject;

endmodule

// File: rtl/pnp_key_compare.sv
// Decides whether a byte continues the current run, and whether that run
// reaches the full key length with this byte.
module pnp_key_compare #(
    parameter int unsigned W     = 8,
    parameter int unsigned LEN   = 32,
    parameter int unsigned CNT_W = 5
) (
    input  logic [W-1:0]     expect_byte,
    input  logic [W-1:0]     got_byte,
    input  logic [CNT_W-1:0] run_cnt,
    output logic             hit,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LEN - 1);

    assign hit  = (expect_byte == got_byte);
    assign last = (run_cnt == LAST_IDX);

endmodule

// File: rtl/pnp_key_detect.sv
module pnp_key_detect #(
    parameter int unsigned KEY_W   = pnp_key_pkg::KEY_W_DEF,
    parameter int unsigned KEY_LEN = pnp_key_pkg::KEY_LEN_DEF,
    parameter logic [KEY_W-1:0] SEED = KEY_W'(pnp_key_pkg::KEY_SEED_DEF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_byte,
    input  logic             wait_key,
    output logic             key_ok,
    output logic [KEY_W-1:0] addr_latch
);
    localparam int unsigned CNT_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

    typedef struct packed {
        logic [KEY_W-1:0] lfsr;
        logic [CNT_W-1:0] cnt;
        logic             accept;
        logic [KEY_W-1:0] latch;
    } key_state_t;

    key_state_t st_d, st_q;

    logic [KEY_W-1:0] lfsr_adv;
    logic             byte_hit;
    logic             run_last;
    logic             key_wr;

    // Observation points for the bound checker.
    logic [KEY_W-1:0] lfsr_cur;
    logic [CNT_W-1:0] cnt_cur;

    pnp_key_lfsr_step #(.W(KEY_W)) u_step (
        .cur    (st_q.lfsr),
        .inject (1'b0),
        .nxt    (lfsr_adv)
    );

    pnp_key_compare #(.W(KEY_W), .LEN(KEY_LEN), .CNT_W(CNT_W)) u_cmp (
        .expect_byte (st_q.lfsr),
        .got_byte    (wr_byte),
        .run_cnt     (st_q.cnt),
        .hit         (byte_hit),
        .last        (run_last)
    );

    assign key_wr = wr_en & wait_key;

    always_comb begin
        st_d        = st_q;
        st_d.accept = 1'b0;
        if (wr_en) begin
            st_d.latch = wr_byte;
        end
        if (key_wr) begin
            if (!byte_hit) begin
                st_d.lfsr = SEED;
                st_d.cnt  = '0;
            end else if (run_last) begin
                st_d.lfsr   = SEED;
                st_d.cnt    = '0;
                st_d.accept = 1'b1;
            end else begin
                st_d.lfsr = lfsr_adv;
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lfsr   <= SEED;
            st_q.cnt    <= '0;
            st_q.accept <= 1'b0;
            st_q.latch  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_ok     = st_q.accept;
    assign addr_latch = st_q.latch;
    assign lfsr_cur   = st_q.lfsr;
    assign cnt_cur    = st_q.cnt;

endmodule

// File: rtl/pnp_key_detect_chk.sv
module pnp_key_detect_chk #(
    parameter int unsigned KEY_W   = 8,
    parameter int unsigned KEY_LEN = 32,
    parameter int unsigned CNT_W   = 5,
    parameter logic [KEY_W-1:0] SEED = 8'h6A
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [KEY_W-1:0] wr_byte,
    input logic             wait_key,
    input logic             key_ok,
    input logic [KEY_W-1:0] addr_latch,
    input logic [KEY_W-1:0] lfsr,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(KEY_LEN - 1);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wait_key && wr_byte == lfsr && cnt != LAST_IDX)
        |=> lfsr == {$past(lfsr[0] ^ lfsr[1]), $past(lfsr[KEY_W-1:1])});

    p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wait_key && wr_byte == lfsr && cnt != LAST_IDX)
        |=> cnt == CNT_W'($past(cnt) + 1'b1));

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wait_key && wr_byte != lfsr) |=> (lfsr == SEED && cnt == '0 && !key_ok));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |=> !key_ok);

    p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |-> $past(wr_en && wait_key && wr_byte == lfsr && cnt == LAST_IDX));

    p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |-> (lfsr == SEED && cnt == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wait_key) |=> ($stable(lfsr) && $stable(cnt) && !key_ok));

    p_latch_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> addr_latch == $past(wr_byte));

    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(addr_latch));

endmodule

bind pnp_key_detect pnp_key_detect_chk #(
    .KEY_W   (KEY_W),
    .KEY_LEN (KEY_LEN),
    .CNT_W   (CNT_W),
    .SEED    (SEED)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_byte    (wr_byte),
    .wait_key   (wait_key),
    .key_ok     (key_ok),
    .addr_latch (addr_latch),
    .lfsr       (lfsr_cur),
    .cnt        (cnt_cur)
);

// File: tb/sim_pnp_key_detect.sv
`timescale 1ns/1ps
module sim_pnp_key_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       wait_key = 1'b0;
    logic       key_ok;
    logic [7:0] addr_latch;

    always #5 clk = ~clk;

    pnp_key_detect u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_byte    (wr_byte),
        .wait_key   (wait_key),
        .key_ok     (key_ok),
        .addr_latch (addr_latch)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // Reference model state
    byte unsigned key_seq[32];
    int           m_pos   = 0;
    bit           m_ok    = 1'b0;
    byte unsigned m_latch = 8'h00;

    function automatic byte unsigned next_key(byte unsigned v);
        byte unsigned top;
        top = (v ^ (v >> 1)) & 8'h01;
        return byte'((v >> 1) | (top << 7));
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, update the model, compare after the edge.
    task automatic step(string tag, bit we, byte unsigned b, bit wk);
        wr_en    = we;
        wr_byte  = b;
        wait_key = wk;
        m_ok = 1'b0;
        if (we) m_latch = b;
        if (we && wk) begin
            if (b == key_seq[m_pos]) begin
                m_pos++;
                if (m_pos == 32) begin
                    m_ok  = 1'b1;
                    m_pos = 0;
                end
            end else begin
                m_pos = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " key_ok"}, 32'(key_ok), 32'(m_ok));
        check("R9 addr_latch", 32'(addr_latch), 32'(m_latch));
    endtask

    task automatic send_key(string tag, int upto, bit gaps);
        for (int i = 0; i < upto; i++) begin
            step(tag, 1'b1, key_seq[i], 1'b1);
            if (gaps && (i % 5 == 2)) step("R8 idle", 1'b0, 8'h00, 1'b1);
        end
    endtask

    initial begin
        key_seq[0] = 8'h6A;
        for (int i = 1; i < 32; i++) key_seq[i] = next_key(key_seq[i-1]);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 key_ok", 32'(key_ok), 32'd0);
        check("R1 addr_latch", 32'(addr_latch), 32'h00);
        // R2: model sequence opening
        check("R2 seq1", 32'(key_seq[1]), 32'hB5);
        check("R2 seq3", 32'(key_seq[3]), 32'hED);

        // R3 R5 R8: full key with idle gaps
        send_key("R5 full", 32, 1'b1);
        // R6: immediately again from the seed
        send_key("R6 again", 32, 1'b0);

        // R4: corrupted sequence, byte 10 wrong, then old sequence continues
        send_key("R4 pre", 10, 1'b0);
        step("R4 bad", 1'b1, key_seq[10] ^ 8'h10, 1'b1);
        for (int i = 11; i < 32; i++) step("R4 tail", 1'b1, key_seq[i], 1'b1);

        // R4: mismatch at byte 17 then full restart
        send_key("R4 pre17", 16, 1'b0);
        step("R4 bad17", 1'b1, 8'h00, 1'b1);
        send_key("R4 restart", 32, 1'b0);

        // R4: mismatch byte equal to the seed does not start a run
        send_key("R4 pre5", 5, 1'b0);
        step("R4 seedbad", 1'b1, 8'h6A, 1'b1);
        for (int i = 1; i < 32; i++) step("R4 noseed", 1'b1, key_seq[i], 1'b1);
        send_key("R4 clean", 32, 1'b0);

        // R7 R9: foreign writes while not waiting are ignored but latched
        send_key("R7 pre", 12, 1'b0);
        step("R7 foreign", 1'b1, 8'h33, 1'b0);
        step("R7 foreign2", 1'b1, 8'hC4, 1'b0);
        for (int i = 12; i < 32; i++) step("R7 tail", 1'b1, key_seq[i], 1'b1);

        // Concurrency: 32nd byte as wait_key drops, then resent
        send_key("R7 pre31", 31, 1'b0);
        step("R7 drop", 1'b1, key_seq[31], 1'b0);
        step("R8 gap", 1'b0, 8'h00, 1'b1);
        step("R5 last", 1'b1, key_seq[31], 1'b1);

        // Reset in the middle of a run returns to R1 state
        send_key("R1 pre", 7, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_pos = 0; m_ok = 1'b0; m_latch = 8'h00;
        check("R1 latch clr", 32'(addr_latch), 32'h00);
        send_key("R1 after", 32, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule